// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a bus-mapped watchdog. A 32-bit up-counter advances on a slow tick enable of about 32 kHz, either on every tick or through a power-of-two prescaler. Software sets a timeout by loading a start value below the wrap point. It keeps the system alive by writing a fresh value to a refresh register, which reloads the counter from the load register. If the counter wraps while the watchdog is armed, the block raises a reset request. Arming and disarming each take a pair of key words written in order.

Writes to the registers that feed the counting logic are posted. Each such register has its own busy bit in a status register. The write takes effect only when that bit drops, a fixed number of slow ticks later. A second write to a register that is still busy is dropped. The bus is a plain single-cycle port: address, write strobe, write data and combinational read data.

Top module: `seqwd_timer`

## Requirements
- R1: After reset the watchdog is disarmed, and the control, counter, load, refresh, key and status registers read 0. `wd_rst_req` is low, and bits 7:0 of the identity register (offset 0) read the `REV_ID` parameter (default 0x21).
- R2: Writing 0xBBBB and then 0x4444 to the key register (offset 6) arms the watchdog.
- R3: Writing 0xAAAA and then 0x5555 to the key register disarms the watchdog.
- R4: A second key word that does not complete the pair cancels the sequence, and that word does not start a new one. The arm state is left unchanged, and a new sequence must begin again from its first word.
- R5: When a write to the refresh register (offset 5) takes effect with a value different from the last one accepted, the counter is set to the load register value (offset 4) on that tick instead of advancing. A repeated value does not reload, and the counter keeps advancing.
- R6: The busy register (offset 7) has one bit per posted register: bit 0 for control (offset 2), bit 1 for counter (offset 3), bit 2 for load, bit 3 for refresh and bit 4 for key. A bit is set from the cycle after an accepted write. It clears on the 4th slow tick after that write, and the written value takes effect on that same tick. A counter write takes effect in place of an advance.
- R7: A write to a posted register whose busy bit is set is ignored.
- R8: Control bit 5 enables the prescaler and bits 4:2 hold the prescale value v. With the prescaler enabled, the counter advances once every 2^v slow ticks, counted from the tick on which the control write took effect. With the prescaler disabled, it advances on every tick.
- R9: When the counter advances from 0xFFFFFFFF while armed, `wd_rst_req` is high for one cycle and the counter is set to the load value. When disarmed, it wraps to 0 and no request is raised.
- R10: Bit 0 of the configuration register (offset 1) is read/write and takes effect at once. Writes to the identity register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable at the slow tick rate |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| wd_rst_req | output | 1 | One-cycle reset request on armed wrap |

## Verification
The assertions assume that `slow_tick` is a single-cycle enable separated by idle cycles. They also assume that the bus writes one register per cycle and holds `bus_we` low between accesses. The stimulus meets both: it pulses the tick every second clock and issues each write as a one-cycle strobe. Arm state is never read directly. The bench infers it by loading a value eight steps below the wrap point, refreshing, and watching whether a reset request appears and where the counter lands. Prescale values are swept over their whole range, and each advance count is compared with a floor division.

// File: rtl/seqwd_pkg.sv
package seqwd_pkg;
  localparam int A_REV  = 0;
  localparam int A_SYSC = 1;
  localparam int A_CTRL = 2;  // first posted register; posted channel i sits at A_CTRL+i
  localparam int A_CNT  = 3;
  localparam int A_LOAD = 4;
  localparam int A_TRIG = 5;
  localparam int A_KEY  = 6;
  localparam int A_BUSY = 7;
  localparam int NCH    = 5;  // posted channels: ctrl, counter, load, refresh, key

  localparam logic [15:0] KEY_ARM1 = 16'hBBBB;
  localparam logic [15:0] KEY_ARM2 = 16'h4444;
  localparam logic [15:0] KEY_DIS1 = 16'hAAAA;
  localparam logic [15:0] KEY_DIS2 = 16'h5555;

  typedef enum logic [1:0] {KS_IDLE, KS_ARM_HALF, KS_DIS_HALF} keystate_e;

  // Prescale terminal value: 2^v - 1
  function automatic logic [6:0] div_last(input logic [2:0] v);
    return 7'((8'd1 << v) - 8'd1);
  endfunction

  // Next counter value on a step, given the arm state
  function automatic logic [31:0] step_value(input logic [31:0] c, input logic [31:0] ld,
                                             input logic armed);
    if (c == 32'hFFFF_FFFF) return armed ? ld : 32'd0;
    return c + 32'd1;
  endfunction
endpackage

// File: rtl/seqwd_post.sv
module seqwd_post #(
  parameter int W     = 32,
  parameter int DELAY = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         pend,
  output logic         commit,
  output logic [W-1:0] data
);
  localparam int CW = $clog2(DELAY + 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shadow_q;
  logic          accept;

  assign accept = wr && !pend_q;
  assign commit = pend_q && tick && (cnt_q == CW'(DELAY - 1));
  assign pend   = pend_q;
  assign data   = shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      shadow_q <= '0;
    end else if (accept) begin
      pend_q   <= 1'b1;
      cnt_q    <= '0;
      shadow_q <= wdata;
    end else if (commit) begin
      pend_q   <= 1'b0;
    end else if (pend_q && tick) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  // R6: a busy bit can only drop on a slow tick
  a_r6_busy_until_tick: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !tick && !accept) |=> pend_q);
  // R7: a write to a busy channel leaves the held value alone
  a_r7_busy_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr && pend_q) |=> $stable(shadow_q));
endmodule

// File: rtl/seqwd_presc.sv
module seqwd_presc #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             clr,
  output logic             step
);
  import seqwd_pkg::*;
  localparam int DW = (1 << PTV_W) - 1;

  logic [DW-1:0] div_q;
  logic          hit;

  assign hit  = (div_q == DW'(div_last(3'(ptv))));
  assign step = tick && (!en || hit);

  always_ff @(posedge clk) begin
    if (rst || clr)       div_q <= '0;
    else if (tick && en)  div_q <= hit ? '0 : div_q + 1'b1;
  end

  // R8: a step never happens without a slow tick
  a_r8_step_needs_tick: assert property (@(posedge clk) disable iff (rst)
    step |-> tick);
endmodule

// File: rtl/seqwd_keyseq.sv
module seqwd_keyseq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic [W-1:0] key,
  output logic         armed
);
  import seqwd_pkg::*;

  keystate_e st_q;
  logic      armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= KS_IDLE;
      armed_q <= 1'b0;
    end else if (commit) begin
      unique case (st_q)
        KS_IDLE: begin
          if (key == W'(KEY_ARM1))      st_q <= KS_ARM_HALF;
          else if (key == W'(KEY_DIS1)) st_q <= KS_DIS_HALF;
        end
        KS_ARM_HALF: begin
          if (key == W'(KEY_ARM2)) armed_q <= 1'b1;
          st_q <= KS_IDLE;
        end
        KS_DIS_HALF: begin
          if (key == W'(KEY_DIS2)) armed_q <= 1'b0;
          st_q <= KS_IDLE;
        end
        default: st_q <= KS_IDLE;
      endcase
    end
  end

  assign armed = armed_q;

  // R2: arming only follows the second arm word
  a_r2_arm_on_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(commit && key == W'(KEY_ARM2)));
  // R3: disarming only follows the second disarm word
  a_r3_disarm_on_pair: assert property (@(posedge clk) disable iff (rst)
    $fell(armed_q) |-> $past(commit && key == W'(KEY_DIS2)));
  // R4: state only moves on a committed key word
  a_r4_idle_without_key: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(armed_q));
endmodule

// File: rtl/seqwd_timer.sv
module seqwd_timer #(
  parameter int          ADDR_W = 3,
  parameter int          DATA_W = 32,
  parameter int          PTV_W  = 3,
  parameter int          DELAY  = 4,
  parameter logic [7:0]  REV_ID = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_rst_req
);
  import seqwd_pkg::*;

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(6'h3C);
  localparam logic [DATA_W-1:0] CNT_MAX   = '1;
  localparam int               PEN_BIT   = PTV_W + 2;

  logic [NCH-1:0]    ch_pend, ch_commit;
  logic [DATA_W-1:0] ch_data [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_post
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(A_CTRL + i);
    seqwd_post #(.W(DATA_W), .DELAY(DELAY)) u_post (
      .clk(clk), .rst(rst), .tick(slow_tick),
      .wr(bus_we && bus_addr == CH_ADDR), .wdata(bus_wdata),
      .pend(ch_pend[i]), .commit(ch_commit[i]), .data(ch_data[i]));
  end

  logic [DATA_W-1:0] ctrl_q, cnt_q, load_q, trig_q, key_q;
  logic              sysc_q, armed, step, trig_reload, cnt_write, rst_q;

  assign cnt_write   = ch_commit[1];
  assign trig_reload = ch_commit[3] && (ch_data[3] != trig_q);

  seqwd_presc #(.PTV_W(PTV_W)) u_presc (
    .clk(clk), .rst(rst), .tick(slow_tick), .en(ctrl_q[PEN_BIT]),
    .ptv(ctrl_q[PEN_BIT-1:2]), .clr(ch_commit[0]), .step(step));

  seqwd_keyseq #(.W(DATA_W)) u_keys (
    .clk(clk), .rst(rst), .commit(ch_commit[4]), .key(ch_data[4]), .armed(armed));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; load_q <= '0; trig_q <= '0; key_q <= '0; sysc_q <= 1'b0;
    end else begin
      if (ch_commit[0]) ctrl_q <= ch_data[0] & CTRL_MASK;
      if (ch_commit[2]) load_q <= ch_data[2];
      if (ch_commit[3]) trig_q <= ch_data[3];
      if (ch_commit[4]) key_q  <= ch_data[4];
      if (bus_we && bus_addr == ADDR_W'(A_SYSC)) sysc_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= step && !cnt_write && !trig_reload && armed && (cnt_q == CNT_MAX);
      if (cnt_write)        cnt_q <= ch_data[1];
      else if (trig_reload) cnt_q <= load_q;
      else if (step)        cnt_q <= step_value(cnt_q, load_q, armed);
    end
  end

  assign wd_rst_req = rst_q;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(A_REV):  bus_rdata = DATA_W'(REV_ID);
      ADDR_W'(A_SYSC): bus_rdata = DATA_W'(sysc_q);
      ADDR_W'(A_CTRL): bus_rdata = ctrl_q;
      ADDR_W'(A_CNT):  bus_rdata = cnt_q;
      ADDR_W'(A_LOAD): bus_rdata = load_q;
      ADDR_W'(A_TRIG): bus_rdata = trig_q;
      ADDR_W'(A_KEY):  bus_rdata = key_q;
      default:         bus_rdata = DATA_W'(ch_pend);
    endcase
  end

  // R9: a reset request only follows a step taken while armed
  a_r9_req_only_armed: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |-> $past(armed && step));
  // R9: an armed wrap lands on the load value
  a_r9_req_reloads: assert property (@(posedge clk) disable iff (rst)
    wd_rst_req |-> cnt_q == $past(load_q));
  // R5: a changed refresh value puts the load value in the counter
  a_r5_refresh_reload: assert property (@(posedge clk) disable iff (rst)
    (trig_reload && !cnt_write) |=> cnt_q == $past(load_q));
endmodule

// File: tb/sim_seqwd_timer.sv
`timescale 1ns/1ps
module sim_seqwd_timer;
  logic        clk = 1'b0, rst = 1'b1, slow_tick = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        wd_rst_req;
  int n_chk = 0, n_bad = 0, pulses = 0;
  logic [31:0] trig_val = 32'd0;

  always #2 clk = ~clk;

  seqwd_timer u0 (.clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_addr(bus_addr),
                  .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                  .wd_rst_req(wd_rst_req));

  always @(posedge clk) if (!rst && wd_rst_req) pulses <= pulses + 1;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic wr_wait(input logic [2:0] a, input logic [31:0] d);
    wr(a, d); ticks(4);
  endtask

  // Infer arm state: load 8 below wrap, refresh, step 10 times
  task automatic probe(input bit exp_armed, input string req);
    logic [31:0] v; int p0;
    wr_wait(3'd4, 32'hFFFF_FFF8);
    trig_val = trig_val + 1;
    wr_wait(3'd5, trig_val);
    rd(3'd3, v); chk(v, 32'hFFFF_FFF8, "R5 refresh before probe");
    p0 = pulses;
    ticks(10);
    chk(32'(pulses - p0), exp_armed ? 32'd1 : 32'd0, {req, " R9 request count"});
    rd(3'd3, v); chk(v, exp_armed ? 32'hFFFF_FFFA : 32'd2, {req, " R9 counter after wrap"});
  endtask

  task automatic keys(input logic [15:0] k1, input logic [15:0] k2);
    wr_wait(3'd6, 32'(k1)); wr_wait(3'd6, 32'(k2));
  endtask

  initial begin : watchdog
    #600000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c0, c1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 2; a < 8; a++) begin
      rd(3'(a), v); chk(v, 32'd0, "R1 register reset value");
    end
    rd(3'd0, v); chk(v & 32'hFF, 32'h21, "R1 identity");
    chk(32'(wd_rst_req), 32'd0, "R1 request low");
    // R10 config and identity
    wr(3'd1, 32'd1); rd(3'd1, v); chk(v, 32'd1, "R10 config set");
    wr(3'd1, 32'd0); rd(3'd1, v); chk(v, 32'd0, "R10 config clear");
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk(v, 32'h21, "R10 identity unwritable");
    // R6 busy bit timing for load
    wr(3'd4, 32'h55);
    rd(3'd7, v); chk(v, 32'h4, "R6 load busy set");
    ticks(3); rd(3'd7, v); chk(v, 32'h4, "R6 still busy after 3 ticks");
    rd(3'd4, v); chk(v, 32'h0, "R6 load not yet applied");
    ticks(1); rd(3'd7, v); chk(v, 32'h0, "R6 busy clear after 4 ticks");
    rd(3'd4, v); chk(v, 32'h55, "R6 load applied");
    // R6 per-register bits
    for (int a = 2; a < 7; a++) begin
      wr(3'(a), 32'd0); rd(3'd7, v); chk(v, 32'd1 << (a - 2), "R6 bit position");
      ticks(4);
    end
    // R7 write while busy
    wr(3'd4, 32'hA); wr(3'd4, 32'hB); ticks(4);
    rd(3'd4, v); chk(v, 32'hA, "R7 busy write dropped");
    // R6 counter write replaces advance
    wr_wait(3'd3, 32'h100); rd(3'd3, v); chk(v, 32'h100, "R6 counter write");
    ticks(5); rd(3'd3, v); chk(v, 32'h105, "R8 advance per tick when off");
    // R5 refresh
    wr_wait(3'd4, 32'h1000);
    trig_val = 32'd1; wr_wait(3'd5, trig_val);
    rd(3'd3, v); chk(v, 32'h1000, "R5 changed value reloads");
    ticks(3); wr_wait(3'd5, trig_val);
    rd(3'd3, v); chk(v, 32'h1007, "R5 repeated value no reload");
    // R2/R3/R4/R9
    probe(1'b0, "R1 disarmed at reset");
    keys(16'hBBBB, 16'h4444); probe(1'b1, "R2 arm");
    keys(16'hAAAA, 16'h5555); probe(1'b0, "R3 disarm");
    keys(16'hBBBB, 16'h1234); probe(1'b0, "R4 broken arm");
    keys(16'hBBBB, 16'hBBBB); wr_wait(3'd6, 32'h4444); probe(1'b0, "R4 restart needed");
    keys(16'hBBBB, 16'h4444); probe(1'b1, "R2 arm again");
    keys(16'hAAAA, 16'h1111); wr_wait(3'd6, 32'h5555); probe(1'b1, "R4 broken disarm");
    keys(16'hAAAA, 16'h5555); probe(1'b0, "R3 disarm again");
    // R8 prescale sweep
    for (int pv = 0; pv < 8; pv++) begin
      int n;
      wr_wait(3'd2, (32'd1 << 5) | (32'(pv) << 2));
      rd(3'd2, v); chk(v, (32'd1 << 5) | (32'(pv) << 2), "R8 control readback");
      rd(3'd3, c0);
      n = (3 << pv) + 1;
      ticks(n);
      rd(3'd3, c1); chk(c1 - c0, 32'(n >> pv), "R8 prescaled advance");
    end
    wr_wait(3'd2, 32'h1C);
    rd(3'd3, c0); ticks(9); rd(3'd3, c1);
    chk(c1 - c0, 32'd9, "R8 prescaler disabled");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule